// File: doc/BRIEF.md
# Command Buffer Structure Checker

This block checks the layout of a command buffer held in a word-addressed memory before another engine is allowed to execute it. A client gives it a first word index and an end index and pulses `start`. The block then reads the header word at the walk pointer and decodes the opcode from the top byte. It moves the pointer past the command: most commands have a fixed length, and the two burst forms add a payload length taken from the header's low half-word. The block never writes anything. It also never fetches payload words, because it counts the payload steps arithmetically.

The walk stops at the first unknown opcode or the first payload step that would go past the end index, and the check fails there. When the pointer reaches or passes the end index with no fault, the check passes. Either way, one `done` pulse reports the verdict and the pointer where the walk stopped.

Top module: `cmdbuf_checker`

## Requirements
- R1: After reset, `busy`, `done` and `mem_rd_en` are low.
- R2: If `start_idx` is greater than `end_idx` when a start is accepted, `done` rises on the next cycle with `result_ok`=0 and `stop_ptr`=`start_idx`, and no memory read is made.
- R3: The opcode is bits 31:24 of the header word, and only the burst opcodes use the header's low bits. Fixed steps in words: opcodes 1, 10 and 11 step 3; opcode 5 steps 2; opcode 6 steps 2; opcode 7 steps 3; opcode 8 steps 1; opcode 9 steps 1; opcode 12 steps 3.
- R4: Opcode 3 steps 2 header words and then one word per item, with the item count N in header bits 15:0. Before each item step, a pointer greater than `end_idx` fails the check at that pointer. N=0 adds no payload.
- R5: Opcode 4 steps 1 header word and then two words per pair, with the pair count N in header bits 15:0. Before each pair step, a pointer greater than `end_idx` fails the check at that pointer, which is `end_idx`+1 or `end_idx`+2.
- R6: Opcode 5 is checked after its step. If the new pointer is greater than `end_idx`, the check fails at the new pointer.
- R7: Any opcode outside {1,3,4,5,6,7,8,9,10,11,12} fails the check at the pointer of that header.
- R8: The first command is always decoded. Walking continues while the pointer is below `end_idx`. Otherwise the check passes with `stop_ptr` equal to the pointer after the last command.
- R9: Each command costs one memory read at the header address, issued in one cycle and decoded in the next. Two reads never fall on adjacent cycles, and payload words are never read.
- R10: `done` is a single-cycle pulse and `busy` is low while it is high. A `start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a check, accepted only while idle |
| start_idx | input | AW | Word index of the first header |
| end_idx | input | AW | End word index of the buffer |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | AW | Memory read word address |
| mem_rd_data | input | 32 | Read data, valid one cycle after the strobe |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle result strobe |
| result_ok | output | 1 | 1 = structure valid, 0 = fault |
| stop_ptr | output | AW+CW+2 | Pointer where the walk stopped or failed |

## Verification
The hardest cases to reach are overruns in the burst forms. In these, a payload count taken from the header makes the pointer cross the end index in the middle of the payload. For pair bursts, whether the failing pointer lands one or two words past the end depends on the parity of the distance. The bench builds random command streams with small counts and cuts them off at random end indices, so many walks stop inside a payload. Directed cases cover both parities, a zero count and an indirect-buffer command that just overruns. A reference walker in the bench steps the payload one item at a time, so the block's closed-form arithmetic is compared against a direct count.

// File: rtl/cmdbuf_checker.sv
module cmdbuf_checker #(
  parameter int AW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_idx,
  input  logic [AW-1:0] end_idx,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [31:0]   mem_rd_data,
  output logic          busy,
  output logic          done,
  output logic          result_ok,
  output logic [AW+CW+1:0] stop_ptr
);
  localparam int PW = AW + CW + 2;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_DEC} st_t;
  st_t st;

  logic [PW-1:0] ptr, lim;
  logic [PW-1:0] nxt, fptr, base, last, gap;
  logic          bad;

  wire [7:0]    op  = mem_rd_data[31:24];
  wire [PW-1:0] cnt = PW'(mem_rd_data[CW-1:0]);

  assign mem_rd_en   = (st == ST_RD);
  assign mem_rd_addr = ptr[AW-1:0];
  assign busy        = (st != ST_IDLE);

  always_comb begin
    bad  = 1'b0;
    fptr = ptr;
    nxt  = ptr;
    base = ptr;
    last = ptr;
    gap  = '0;
    case (op)
      8'd1, 8'd10, 8'd11: begin bad = ptr > lim; nxt = ptr + PW'(3); end
      8'd8:  begin bad = ptr > lim; nxt = ptr + PW'(1); end
      8'd5:  begin nxt = ptr + PW'(2); bad = nxt > lim; fptr = nxt; end
      8'd6:  nxt = ptr + PW'(2);
      8'd7:  nxt = ptr + PW'(3);
      8'd9:  nxt = ptr + PW'(1);
      8'd12: nxt = ptr + PW'(3);
      8'd3: begin
        base = ptr + PW'(2);
        last = base + cnt - PW'(1);
        bad  = (cnt != '0) && (last > lim);
        fptr = (base > lim) ? base : lim + PW'(1);
        nxt  = base + cnt;
      end
      8'd4: begin
        base = ptr + PW'(1);
        last = base + ((cnt - PW'(1)) << 1);
        gap  = lim - base;
        bad  = (cnt != '0) && (last > lim);
        fptr = (base > lim) ? base : lim + PW'(2) - PW'(gap[0]);
        nxt  = base + (cnt << 1);
      end
      default: bad = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      ptr       <= '0;
      lim       <= '0;
      done      <= 1'b0;
      result_ok <= 1'b0;
      stop_ptr  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          ptr <= PW'(start_idx);
          lim <= PW'(end_idx);
          if (start_idx > end_idx) begin
            done      <= 1'b1;
            result_ok <= 1'b0;
            stop_ptr  <= PW'(start_idx);
          end else begin
            st <= ST_RD;
          end
        end
        ST_RD: st <= ST_DEC;
        default: begin
          if (bad) begin
            done      <= 1'b1;
            result_ok <= 1'b0;
            stop_ptr  <= fptr;
            st        <= ST_IDLE;
          end else if (nxt < lim) begin
            ptr <= nxt;
            st  <= ST_RD;
          end else begin
            done      <= 1'b1;
            result_ok <= 1'b1;
            stop_ptr  <= nxt;
            st        <= ST_IDLE;
          end
        end
      endcase
    end
  end

  a_r2_reversed_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && start_idx > end_idx) |=>
      (done && !result_ok && stop_ptr == PW'($past(start_idx))));

  a_r9_first_read: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && start_idx <= end_idx) |=>
      (mem_rd_en && mem_rd_addr == $past(start_idx)));

  a_r9_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/tb_cmdbuf_checker.sv
`timescale 1ns/1ps
module tb_cmdbuf_checker;
  localparam int AW = 8;
  localparam int CW = 16;
  localparam int PW = AW + CW + 2;

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] start_idx = '0, end_idx = '0;
  logic mem_rd_en, busy, done, result_ok;
  logic [AW-1:0] mem_rd_addr;
  logic [31:0] mem_rd_data;
  logic [PW-1:0] stop_ptr;

  logic [31:0] mem [0:(1<<AW)-1];
  int rd_cnt = 0;
  int total = 0, failed = 0, cycles = 0;

  always #4 clk = ~clk;

  cmdbuf_checker #(.AW(AW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_idx(start_idx),
    .end_idx(end_idx), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .busy(busy), .done(done),
    .result_ok(result_ok), .stop_ptr(stop_ptr));

  always_ff @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
  always_ff @(posedge clk) if (mem_rd_en) rd_cnt <= rd_cnt + 1;

  task automatic summary();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; failed++;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cycles);
      summary();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic void model(input int s, input int e,
      output bit ok, output int ptr, output int ncmd);
    int p, n;
    bit [7:0] op;
    ncmd = 0;
    if (s > e) begin ok = 0; ptr = s; return; end
    p = s;
    do begin
      op = mem[p][31:24];
      n  = int'(mem[p][15:0]);
      ncmd++;
      case (op)
        1, 10, 11: begin if (p > e) begin ok = 0; ptr = p; return; end p += 3; end
        8: begin if (p > e) begin ok = 0; ptr = p; return; end p += 1; end
        5: begin p += 2; if (p > e) begin ok = 0; ptr = p; return; end end
        6: p += 2;
        7, 12: p += 3;
        9: p += 1;
        3: begin
          p += 2;
          for (int i = 0; i < n; i++) begin
            if (p > e) begin ok = 0; ptr = p; return; end
            p += 1;
          end
        end
        4: begin
          p += 1;
          for (int i = 0; i < n; i++) begin
            if (p > e) begin ok = 0; ptr = p; return; end
            p += 2;
          end
        end
        default: begin ok = 0; ptr = p; return; end
      endcase
    end while (p < e);
    ok = 1; ptr = p;
  endfunction

  task automatic run(input int s, input int e, output bit ok, output int ptr,
      output int cyc, output int reads);
    int r0;
    r0 = rd_cnt;
    @(negedge clk);
    start = 1; start_idx = AW'(s); end_idx = AW'(e);
    @(negedge clk);
    start = 0; cyc = 1;
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
    ok = result_ok; ptr = int'(stop_ptr); reads = rd_cnt - r0;
  endtask

  task automatic check_run(input string req, input int s, input int e);
    bit ok, mok; int ptr, cyc, reads, mptr, mn;
    model(s, e, mok, mptr, mn);
    run(s, e, ok, ptr, cyc, reads);
    chk({req, " verdict"}, int'(ok), int'(mok));
    chk({req, " stop_ptr"}, ptr, mptr);
    chk("R9 header reads", reads, mn);
  endtask

  function automatic bit [7:0] pick_op();
    int r;
    r = int'($urandom % 13);
    case (r)
      0: return 8'd1;  1: return 8'd10; 2: return 8'd11; 3: return 8'd5;
      4: return 8'd6;  5: return 8'd7;  6: return 8'd8;  7: return 8'd9;
      8: return 8'd12; 9, 10: return 8'd3; 11: return 8'd4;
      default: return ($urandom % 4 == 0) ? 8'(13 + $urandom % 243) : 8'd6;
    endcase
  endfunction

  task automatic gen(input int s, output int q);
    bit [7:0] op; int n, step;
    q = s;
    while (q < 225) begin
      op = pick_op();
      n = 0;
      step = 1;
      if (op == 3) n = int'($urandom % 6);
      if (op == 4) n = int'($urandom % 5);
      mem[q] = {op, 8'($urandom), 16'($urandom)};
      if (op == 3 || op == 4) mem[q][15:0] = 16'(n);
      case (op)
        1, 10, 11, 7, 12: step = 3;
        5, 6: step = 2;
        3: step = 2 + n;
        4: step = 1 + 2 * n;
        default: step = 1;
      endcase
      for (int k = 1; k < step; k++) mem[q + k] = $urandom;
      q += step;
      if ($urandom % 6 == 0) break;
    end
  endtask

  initial begin
    bit ok; int ptr, cyc, reads, q, s, e;
    bit mok; int mptr, mn;
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < (1 << AW); i++) mem[i] = 32'h0600_0000;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 rd_en", int'(mem_rd_en), 0);
    rst_n = 1;
    @(negedge clk);

    // R2 reversed range
    run(10, 5, ok, ptr, cyc, reads);
    chk("R2 verdict", int'(ok), 0);
    chk("R2 stop_ptr", ptr, 10);
    chk("R2 latency", cyc, 1);
    chk("R2 no read", reads, 0);

    // R8/R3 single command with start==end
    mem[20] = {8'd6, 24'h0};
    run(20, 20, ok, ptr, cyc, reads);
    chk("R8 single verdict", int'(ok), 1);
    chk("R3 gen irq step", ptr, 22);

    // R3 low bits ignored for fixed commands
    mem[30] = {8'd8, 8'hFF, 16'hFFFF};
    mem[31] = {8'd9, 8'h12, 16'h8000};
    run(30, 32, ok, ptr, cyc, reads);
    chk("R3 fixed verdict", int'(ok), 1);
    chk("R3 fixed stop", ptr, 32);
    chk("R9 two headers", reads, 2);

    // R7 unknown opcodes
    mem[40] = {8'd6, 24'h0}; mem[42] = 32'h0;
    run(40, 50, ok, ptr, cyc, reads);
    chk("R7 op0 verdict", int'(ok), 0);
    chk("R7 op0 ptr", ptr, 42);
    mem[60] = {8'd2, 24'h0};
    run(60, 70, ok, ptr, cyc, reads);
    chk("R7 op2 ptr", ptr, 60);
    chk("R7 op2 verdict", int'(ok), 0);

    // R6 indirect checked after step
    mem[70] = {8'd5, 24'h0};
    run(70, 71, ok, ptr, cyc, reads);
    chk("R6 overrun verdict", int'(ok), 0);
    chk("R6 overrun ptr", ptr, 72);
    run(70, 72, ok, ptr, cyc, reads);
    chk("R6 fit verdict", int'(ok), 1);
    chk("R6 fit ptr", ptr, 72);

    // R4 item burst
    mem[80] = {8'd3, 8'h00, 16'd5};
    run(80, 83, ok, ptr, cyc, reads);
    chk("R4 overrun verdict", int'(ok), 0);
    chk("R4 overrun ptr", ptr, 84);
    chk("R9 payload unread", reads, 1);
    run(80, 87, ok, ptr, cyc, reads);
    chk("R4 fit verdict", int'(ok), 1);
    chk("R4 fit ptr", ptr, 87);
    mem[110] = {8'd3, 8'hAB, 16'd0};
    run(110, 112, ok, ptr, cyc, reads);
    chk("R4 zero count ptr", ptr, 112);
    chk("R4 zero count verdict", int'(ok), 1);

    // R5 pair burst, odd and even distance
    mem[100] = {8'd4, 8'h00, 16'd3};
    run(100, 102, ok, ptr, cyc, reads);
    chk("R5 odd gap ptr", ptr, 103);
    chk("R5 odd gap verdict", int'(ok), 0);
    run(100, 103, ok, ptr, cyc, reads);
    chk("R5 even gap ptr", ptr, 105);
    run(100, 107, ok, ptr, cyc, reads);
    chk("R5 fit verdict", int'(ok), 1);
    chk("R5 fit ptr", ptr, 107);

    // R10 start ignored while busy
    for (int i = 130; i < 150; i++) mem[i] = {8'd9, 24'h0};
    model(130, 145, mok, mptr, mn);
    @(negedge clk);
    start = 1; start_idx = 8'd130; end_idx = 8'd145;
    @(negedge clk); start = 0;
    @(negedge clk); start = 1; start_idx = 8'd9; end_idx = 8'd1;
    @(negedge clk); start = 0;
    chk("R10 no early done", int'(done), 0);
    cyc = 0;
    while (!done && cyc < 1000) begin @(negedge clk); cyc++; end
    chk("R10 done busy low", int'(busy), 0);
    chk("R10 ignored start ptr", int'(stop_ptr), mptr);
    chk("R10 ignored start verdict", int'(result_ok), int'(mok));
    @(negedge clk);
    chk("R10 single pulse", int'(done), 0);

    // random streams
    for (int t = 0; t < 120; t++) begin
      s = int'($urandom % 150);
      gen(s, q);
      e = s + int'($urandom % (q - s + 3));
      if (e > 255) e = 255;
      check_run("R8 random", s, e);
    end

    summary();
  end
endmodule